// File: doc/BRIEF.md
# Conditional-block state sequencer

This block keeps the 8-bit state that governs a short run of conditionally executed instructions, up to four, that follow an if-then prefix instruction. The state is split into a 4-bit base condition in bits [7:4] and a 4-bit mask in bits [3:0]. The execute stage reads the current condition and an active flag. Each retired instruction pulses the advance input. On that pulse the state either takes a pending value or steps the mask one place.

A pending register holds a new state. The decoder loads it when it finds a prefix instruction, and the restore path loads it when a status image is written back. The pending value becomes live at the next advance and has priority over the shift step. When an exception is taken, the block copies the live state into a saved 6-bit upper field and a saved 2-bit lower field. It then clears both the live state and the pending state. The same 6/2 split of the live state is also driven out at all times.

Top module: `cond_block_seq`

## Requirements
- R1: `cond_o` equals state bits [7:4]. `active_o` is high exactly when state bits [3:0] (the mask) are nonzero. `live_hi_o` equals state bits [7:2] and `live_lo_o` equals state bits [1:0].
- R2: On an advance with no pending state and a nonzero state, the mask shifts left by one. Bit 4 of the shifted value becomes condition bit 0, condition bits [3:1] are kept, and the new mask is the low four bits of the shifted value.
- R3: If the shifted mask is zero, the whole state becomes 0x00, including the condition field.
- R4: On an advance with a nonzero pending state, the state takes the pending value and the shift step is not applied. The pending register is then cleared, so the next advance shifts normally.
- R5: An advance with both the state and the pending register at zero leaves the state at 0x00.
- R6: A prefix load (`pfx_vld_i`) writes `pfx_state_i` into the pending register. It does not change the live state until the next advance. When an advance occurs in the same cycle, that advance uses the old pending value.
- R7: A restore load (`rest_vld_i`) writes ((`rest_hi_i` << 2) & 0xFC) | (`rest_lo_i` & 0x3) into the pending register. A prefix load in the same cycle takes precedence over a restore.
- R8: On `exc_i`, `saved_hi_o` and `saved_lo_o` capture bits [7:2] and [1:0] of the state held before that edge. They keep that value until the next exception.
- R9: On `exc_i`, both the live state and the pending state become zero. This overrides any advance or load in the same cycle.
- R10: With no advance, no load taking effect and no exception, the live state holds its value.
- R11: Reset (`rst_ni` low, asynchronous) clears the live state, the pending state and the saved fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | One instruction retired |
| pfx_vld_i | input | 1 | Prefix detected, load pending state |
| pfx_state_i | input | 8 | State carried by the prefix |
| rest_vld_i | input | 1 | Restore from status image |
| rest_hi_i | input | 6 | Upper 6-bit field of the image |
| rest_lo_i | input | 2 | Lower 2-bit field of the image |
| exc_i | input | 1 | Exception entry |
| cond_o | output | 4 | Current base condition |
| active_o | output | 1 | Conditional run in progress |
| live_hi_o | output | 6 | State bits [7:2] |
| live_lo_o | output | 2 | State bits [1:0] |
| saved_hi_o | output | 6 | Upper field captured at exception entry |
| saved_lo_o | output | 2 | Lower field captured at exception entry |

## Verification
The bench runs one-, two-, three- and four-instruction runs with mixed then/else masks and compares every step against hand-derived state values. A design that fails to feed shifted bit 4 into the condition would show the wrong else/then condition mid-run. A design that clears only the mask would leave a stale nonzero condition after the run ends. Further tests load a pending state while a run is active, and load a prefix in the same cycle as an advance. A design that ranks the shift above the pending state would keep stepping the old run, and one that applies a load at once would skip an instruction. The exception tests check that the saved fields hold the state from before the edge rather than the cleared value, and that a pending restore cannot survive the clear.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned MASK_W = 4;
  localparam int unsigned LO_W   = 2;
  localparam int unsigned ST_W   = COND_W + MASK_W;
  localparam int unsigned HI_W   = ST_W - LO_W;
endpackage

// File: rtl/cbs_advance.sv
module cbs_advance #(
  parameter int unsigned COND_W = cbs_pkg::COND_W,
  parameter int unsigned MASK_W = cbs_pkg::MASK_W,
  localparam int unsigned ST_W  = COND_W + MASK_W
) (
  input  logic [ST_W-1:0] cur_i,
  output logic [ST_W-1:0] nxt_o
);
  logic [MASK_W:0]   shifted;
  logic [COND_W-1:0] cond_q;

  always_comb begin
    shifted = {cur_i[MASK_W-1:0], 1'b0};
    cond_q  = cur_i[ST_W-1:MASK_W];
    if (shifted[MASK_W-1:0] == '0) begin
      nxt_o = '0;
    end else begin
      nxt_o = {cond_q[COND_W-1:1], shifted[MASK_W], shifted[MASK_W-1:0]};
    end
  end
endmodule

// File: rtl/cbs_pending.sv
module cbs_pending #(
  parameter int unsigned ST_W = cbs_pkg::ST_W,
  parameter int unsigned LO_W = cbs_pkg::LO_W,
  localparam int unsigned HI_W = ST_W - LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            exc_i,
  input  logic            pfx_vld_i,
  input  logic [ST_W-1:0] pfx_state_i,
  input  logic            rest_vld_i,
  input  logic [HI_W-1:0] rest_hi_i,
  input  logic [LO_W-1:0] rest_lo_i,
  output logic [ST_W-1:0] pend_o
);
  logic [ST_W-1:0] rebuilt;
  logic [ST_W-1:0] pend_d;

  // rebuild image: upper field shifted into place, lower field masked in
  always_comb begin
    rebuilt = (ST_W'(rest_hi_i) << LO_W) | ST_W'(rest_lo_i);
    if (exc_i)           pend_d = '0;
    else if (pfx_vld_i)  pend_d = pfx_state_i;
    else if (rest_vld_i) pend_d = rebuilt;
    else if (adv_i)      pend_d = '0;
    else                 pend_d = pend_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_d;
  end

  assert_exc_pend_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> pend_o == '0);
  assert_pfx_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfx_vld_i && !exc_i) |=> pend_o == $past(pfx_state_i));
endmodule

// File: rtl/cbs_save.sv
module cbs_save #(
  parameter int unsigned ST_W = cbs_pkg::ST_W,
  parameter int unsigned LO_W = cbs_pkg::LO_W,
  localparam int unsigned HI_W = ST_W - LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic [ST_W-1:0] cur_i,
  output logic [HI_W-1:0] saved_hi_o,
  output logic [LO_W-1:0] saved_lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_hi_o <= '0;
      saved_lo_o <= '0;
    end else if (exc_i) begin
      saved_hi_o <= cur_i[ST_W-1:LO_W];
      saved_lo_o <= cur_i[LO_W-1:0];
    end
  end

  assert_exc_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> {saved_hi_o, saved_lo_o} == $past(cur_i));
  assert_saved_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_i |=> $stable({saved_hi_o, saved_lo_o}));
endmodule

// File: rtl/cond_block_seq.sv
module cond_block_seq #(
  parameter int unsigned COND_W = cbs_pkg::COND_W,
  parameter int unsigned MASK_W = cbs_pkg::MASK_W,
  parameter int unsigned LO_W   = cbs_pkg::LO_W,
  localparam int unsigned ST_W  = COND_W + MASK_W,
  localparam int unsigned HI_W  = ST_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              pfx_vld_i,
  input  logic [ST_W-1:0]   pfx_state_i,
  input  logic              rest_vld_i,
  input  logic [HI_W-1:0]   rest_hi_i,
  input  logic [LO_W-1:0]   rest_lo_i,
  input  logic              exc_i,
  output logic [COND_W-1:0] cond_o,
  output logic              active_o,
  output logic [HI_W-1:0]   live_hi_o,
  output logic [LO_W-1:0]   live_lo_o,
  output logic [HI_W-1:0]   saved_hi_o,
  output logic [LO_W-1:0]   saved_lo_o
);
  logic [ST_W-1:0] cur_q, cur_d, stepped, pend;

  cbs_advance #(.COND_W(COND_W), .MASK_W(MASK_W)) u_adv (
    .cur_i (cur_q),
    .nxt_o (stepped)
  );

  cbs_pending #(.ST_W(ST_W), .LO_W(LO_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv_i),
    .exc_i       (exc_i),
    .pfx_vld_i   (pfx_vld_i),
    .pfx_state_i (pfx_state_i),
    .rest_vld_i  (rest_vld_i),
    .rest_hi_i   (rest_hi_i),
    .rest_lo_i   (rest_lo_i),
    .pend_o      (pend)
  );

  cbs_save #(.ST_W(ST_W), .LO_W(LO_W)) u_save (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (exc_i),
    .cur_i      (cur_q),
    .saved_hi_o (saved_hi_o),
    .saved_lo_o (saved_lo_o)
  );

  // pending state outranks the shift step
  always_comb begin
    if (exc_i)              cur_d = '0;
    else if (!adv_i)        cur_d = cur_q;
    else if (pend != '0)    cur_d = pend;
    else if (cur_q != '0)   cur_d = stepped;
    else                    cur_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign cond_o    = cur_q[ST_W-1:MASK_W];
  assign active_o  = |cur_q[MASK_W-1:0];
  assign live_hi_o = cur_q[ST_W-1:LO_W];
  assign live_lo_o = cur_q[LO_W-1:0];

  assert_pend_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !exc_i && pend != '0) |=> cur_q == $past(pend));
  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !exc_i && pend == '0 && cur_q == '0) |=> cur_q == '0);
  assert_exc_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> cur_q == '0);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !exc_i) |=> $stable(cur_q));
  assert_run_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !exc_i && pend == '0 && active_o && cur_q[MASK_W-2:0] == '0)
      |=> cur_q == '0);
endmodule

// File: tb/cond_block_seq_bench.sv
module cond_block_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv = 1'b0, pfx_v = 1'b0, rest_v = 1'b0, exc = 1'b0;
  logic [7:0] pfx_s = '0;
  logic [5:0] rest_hi = '0;
  logic [1:0] rest_lo = '0;
  logic [3:0] cond;
  logic       active;
  logic [5:0] live_hi, saved_hi;
  logic [1:0] live_lo, saved_lo;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_block_seq u_cond_block_seq (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .pfx_vld_i(pfx_v),
    .pfx_state_i(pfx_s), .rest_vld_i(rest_v), .rest_hi_i(rest_hi),
    .rest_lo_i(rest_lo), .exc_i(exc), .cond_o(cond), .active_o(active),
    .live_hi_o(live_hi), .live_lo_o(live_lo),
    .saved_hi_o(saved_hi), .saved_lo_o(saved_lo)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // state check covering R1 output mapping
  task automatic chk_state(string req, logic [7:0] exp);
    chk(req, {live_hi, live_lo}, exp);
    chk({req, "/R1 cond"}, {4'h0, cond}, {4'h0, exp[7:4]});
    chk({req, "/R1 active"}, {7'h0, active}, {7'h0, exp[3:0] != 4'h0});
  endtask

  task automatic drive(bit a, bit pv, logic [7:0] ps, bit rv,
                       logic [5:0] rh, logic [1:0] rl, bit e);
    @(negedge clk);
    adv = a; pfx_v = pv; pfx_s = ps; rest_v = rv; rest_hi = rh; rest_lo = rl; exc = e;
    @(negedge clk);
    adv = 0; pfx_v = 0; rest_v = 0; exc = 0;
  endtask

  task automatic step();
    drive(1, 0, 8'h00, 0, 6'h0, 2'h0, 0);
  endtask

  // prefix retires: pending loaded, live state untouched (R6)
  task automatic start_run(logic [7:0] s);
    drive(1, 1, s, 0, 6'h0, 2'h0, 0);
    chk_state("R6 load deferred", 8'h00);
    step();
    chk_state("R4 pending taken", s);
  endtask

  task automatic t_reset();
    chk_state("R11 reset", 8'h00);
    chk("R11 saved", {saved_hi, saved_lo}, 8'h00);
  endtask

  task automatic t_run1();
    start_run(8'hE8);
    step(); chk_state("R3 one-instr end", 8'h00);
  endtask

  task automatic t_run2();
    start_run(8'h1C);
    step(); chk_state("R2 two-instr s1", 8'h18);
    step(); chk_state("R3 two-instr end", 8'h00);
  endtask

  task automatic t_run3();
    start_run(8'hA6);
    step(); chk_state("R2 three-instr s1", 8'hAC);
    step(); chk_state("R2 three-instr s2", 8'hB8);
    step(); chk_state("R3 three-instr end", 8'h00);
  endtask

  task automatic t_run4();
    start_run(8'h05);
    step(); chk_state("R2 four-instr s1", 8'h0A);
    step(); chk_state("R2 four-instr s2", 8'h14);
    step(); chk_state("R2 four-instr s3", 8'h08);
    step(); chk_state("R3 four-instr end", 8'h00);
  endtask

  task automatic t_idle();
    step(); chk_state("R5 idle advance", 8'h00);
  endtask

  task automatic t_prio();
    start_run(8'h1C);
    drive(0, 1, 8'h05, 0, 6'h0, 2'h0, 0);
    chk_state("R10 hold while loading", 8'h1C);
    step(); chk_state("R4 pending over shift", 8'h05);
    step(); chk_state("R4 pending cleared", 8'h0A);
    step(); step(); step();
    chk_state("R3 drain", 8'h00);
  endtask

  task automatic t_hold();
    start_run(8'hA6);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk_state("R10 no advance hold", 8'hA6);
    step(); step(); step();
  endtask

  task automatic t_restore();
    drive(0, 0, 8'h00, 1, 6'b101101, 2'b10, 0);
    chk_state("R7 restore deferred", 8'h00);
    step(); chk_state("R7 restore image", 8'hB6);
    drive(1, 1, 8'h28, 1, 6'h3F, 2'h3, 0);
    chk_state("R2 shift with old pending", 8'hAC);
    step(); chk_state("R7 prefix over restore", 8'h28);
    step(); step(); step();
  endtask

  task automatic t_exc();
    start_run(8'hA6);
    step(); chk_state("R2 pre-exception", 8'hAC);
    drive(1, 0, 8'h00, 1, 6'h2D, 2'h2, 1);
    chk("R8 saved hi", {2'b00, saved_hi}, 8'h2B);
    chk("R8 saved lo", {6'h0, saved_lo}, 8'h00);
    chk_state("R9 live cleared", 8'h00);
    step(); chk_state("R9 pending cleared", 8'h00);
    step();
    chk("R8 saved held", {saved_hi, saved_lo}, 8'hAC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run1(); t_run2(); t_run3(); t_run4();
    t_idle(); t_prio(); t_hold(); t_restore(); t_exc();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule